// File: doc/BRIEF.md
# Configurable Synchronous Serial Receiver

This block takes a serial bit stream together with its bit clock and a frame line, and turns each frame into a run of parallel data words. The serial clock, data and frame inputs are sampled into the system clock domain. A bit is taken at every rising edge of the serial clock. A frame begins at a rising edge of the frame line. The word length, the bit order and the number of words per frame are all programmable. Each finished word appears right-aligned on a parallel output, with a one-cycle valid strobe and a tag that classifies it as byte, half-word or full word.

When the frame-sync mode selects a pulse, the bits that arrive while the sync pulse is active are gathered into a separate sync-data register. A loop control swaps the three external serial inputs for the local transmit-side clock, data and frame lines. This allows the receive path to be exercised with no external wiring.

Top module: `ssr_rx`

## Requirements
- R1: With a word-length setting L (1 to 31), each word is built from exactly L+1 received bits. The next word starts with the bit that follows.
- R2: When `msb_first` is 0, the first bit of a word lands in bit 0 of `rx_word`, the second bit in bit 1, and so on.
- R3: When `msb_first` is 1, the first bit of a word lands in bit L of `rx_word` and the last bit in bit 0. In both orders every bit of `rx_word` above bit L reads 0.
- R4: With a words-per-frame setting N (0 to 15), exactly N+1 words are emitted after a frame start. `busy` then drops, and no further word is emitted until a new frame start.
- R5: `rx_size` is 0 (byte) for L of 7 or less, 1 (half-word) for L from 8 to 15, and 2 (word) for L from 16 to 31.
- R6: `rx_valid` is high for exactly one system clock cycle per word. It is high in the cycle right after the clock edge that samples the word's last bit.
- R7: When `loop_en` is 1, the clock, data and frame are taken from `loc_sck`, `loc_sd` and `loc_fs`, and the external inputs are ignored. When `loop_en` is 0, the external inputs are used.
- R8: When `sync_mode` is 1 (negative pulse) or 2 (positive pulse) and `sync_len` S is nonzero, S bits are captured into `sync_data`. These are the bit sampled with the frame start followed by the next S-1 bits. The first of them goes to bit 0, higher bits are cleared, and `sync_valid` pulses for one cycle. Data starts with the bit after them. In any other `sync_mode`, `sync_data` is left unchanged, `sync_valid` stays low, and data starts with the bit after the start bit.
- R9: A rising edge of the frame line while a frame is in progress is ignored, and the current frame goes on unchanged.
- R10: A frame start is a serial-clock rising edge at which the sampled frame line is 1 after being 0 at the previous one. Bits received while idle without such an edge produce no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | 1 selects the local transmit-side lines |
| ext_sck | input | 1 | External serial clock |
| ext_sd | input | 1 | External serial data |
| ext_fs | input | 1 | External frame line |
| loc_sck | input | 1 | Local transmit clock used in loop mode |
| loc_sd | input | 1 | Local transmit data used in loop mode |
| loc_fs | input | 1 | Local transmit frame used in loop mode |
| word_len | input | 5 | L: each word carries L+1 bits |
| msb_first | input | 1 | Bit order: 1 means the first bit is the most significant |
| words_per_frame | input | 4 | N: N+1 words per frame |
| sync_mode | input | 3 | Frame-sync mode; 1 and 2 enable sync capture |
| sync_len | input | 4 | S: number of sync bits captured |
| rx_word | output | 32 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| rx_size | output | 2 | Size tag: 0 byte, 1 half-word, 2 word |
| sync_data | output | 16 | Captured sync bits |
| sync_valid | output | 1 | One-cycle strobe for new sync data |
| busy | output | 1 | High while a frame is in progress |

## Verification
The bench targets several corner cases, and each one is tied to the failure it would expose:

- Word length at the size-tag boundaries (L of 7, 8, 15, 16 and 31): a wrong compare gives the wrong tag, and a wrong end-of-word test gives truncated or overlong words.
- MSB-first words shorter than 32 bits: a design that does not right-align them puts the data in the upper bits.
- A frame-line rise in the middle of a frame: a design that restarts on it loses or duplicates words.
- The largest frame (16 words) and the smallest: counting errors show up here.
- Sync capture enabled versus a non-pulse mode with a nonzero sync length: a design that gets this wrong eats data bits or overwrites the sync register.
- Loop frames with noise on the external pins: these show whether the input select is honoured.

// File: rtl/ssr_rx.sv
module ssr_rx #(
  parameter int DW  = 32,
  parameter int LW  = 5,
  parameter int NW  = 4,
  parameter int SW  = 16,
  parameter int SLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           loop_en,
  input  logic           ext_sck,
  input  logic           ext_sd,
  input  logic           ext_fs,
  input  logic           loc_sck,
  input  logic           loc_sd,
  input  logic           loc_fs,
  input  logic [LW-1:0]  word_len,
  input  logic           msb_first,
  input  logic [NW-1:0]  words_per_frame,
  input  logic [2:0]     sync_mode,
  input  logic [SLW-1:0] sync_len,
  output logic [DW-1:0]  rx_word,
  output logic           rx_valid,
  output logic [1:0]     rx_size,
  output logic [SW-1:0]  sync_data,
  output logic           sync_valid,
  output logic           busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA} st_t;

  st_t            st;
  logic           sck_q, sck_q2, sd_q, fs_q, fs_last;
  logic [LW-1:0]  bit_cnt;
  logic [NW-1:0]  word_cnt;
  logic [SLW-1:0] sync_cnt;
  logic [DW-1:0]  shreg;
  logic [SW-1:0]  sync_buf;

  wire sel_sck = loop_en ? loc_sck : ext_sck;
  wire sel_sd  = loop_en ? loc_sd  : ext_sd;
  wire sel_fs  = loop_en ? loc_fs  : ext_fs;

  wire strobe  = sck_q & ~sck_q2;
  wire fs_rise = strobe & fs_q & ~fs_last;
  wire sync_on = ((sync_mode == 3'd1) || (sync_mode == 3'd2)) && (sync_len != '0);

  wire [LW-1:0] pos      = msb_first ? (word_len - bit_cnt) : bit_cnt;
  wire [DW-1:0] word_nxt = shreg | (DW'(sd_q) << pos);
  wire [SW-1:0] sync_nxt = sync_buf | (SW'(sd_q) << sync_cnt);
  wire [1:0]    size_tag = (word_len <= LW'(7))  ? 2'd0 :
                           (word_len <= LW'(15)) ? 2'd1 : 2'd2;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      sck_q2  <= 1'b0;
      sd_q    <= 1'b0;
      fs_q    <= 1'b0;
      fs_last <= 1'b0;
    end else begin
      sck_q  <= sel_sck;
      sck_q2 <= sck_q;
      sd_q   <= sel_sd;
      fs_q   <= sel_fs;
      if (strobe) fs_last <= fs_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      word_cnt   <= '0;
      sync_cnt   <= '0;
      shreg      <= '0;
      sync_buf   <= '0;
      rx_word    <= '0;
      rx_valid   <= 1'b0;
      rx_size    <= 2'd0;
      sync_data  <= '0;
      sync_valid <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      sync_valid <= 1'b0;
      case (st)
        ST_IDLE: if (fs_rise) begin
          bit_cnt  <= '0;
          word_cnt <= '0;
          shreg    <= '0;
          if (sync_on) begin
            sync_buf <= SW'(sd_q);
            sync_cnt <= SLW'(1);
            if (sync_len == SLW'(1)) begin
              sync_data  <= SW'(sd_q);
              sync_valid <= 1'b1;
              st         <= ST_DATA;
            end else begin
              st <= ST_SYNC;
            end
          end else begin
            st <= ST_DATA;
          end
        end
        ST_SYNC: if (strobe) begin
          sync_buf <= sync_nxt;
          sync_cnt <= sync_cnt + 1'b1;
          if (sync_cnt == sync_len - 1'b1) begin
            sync_data  <= sync_nxt;
            sync_valid <= 1'b1;
            st         <= ST_DATA;
          end
        end
        ST_DATA: if (strobe) begin
          if (bit_cnt == word_len) begin
            rx_word  <= word_nxt;
            rx_valid <= 1'b1;
            rx_size  <= size_tag;
            shreg    <= '0;
            bit_cnt  <= '0;
            if (word_cnt == words_per_frame) st <= ST_IDLE;
            else word_cnt <= word_cnt + 1'b1;
          end else begin
            shreg   <= word_nxt;
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ssr_rx_chk.sv
module ssr_rx_chk #(
  parameter int DW = 32,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] rx_word,
  input logic          rx_valid,
  input logic [1:0]    rx_size,
  input logic [LW-1:0] word_len,
  input logic          sync_valid,
  input logic          busy
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R6

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (((rx_word >> word_len) >> 1) == '0)); // R3

  AST_SIZE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_size == ((word_len < LW'(8)) ? 2'd0 : (word_len < LW'(16)) ? 2'd1 : 2'd2))); // R5

  AST_LAST_WORD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_valid); // R4

  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !rx_valid); // R4

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> !sync_valid); // R8

endmodule

bind ssr_rx ssr_rx_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
  .rx_size(rx_size), .word_len(word_len), .sync_valid(sync_valid), .busy(busy)
);

// File: tb/ssr_rx_bench.sv
module ssr_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_en = 1'b0;
  logic ext_sck = 1'b0, ext_sd = 1'b0, ext_fs = 1'b0;
  logic loc_sck = 1'b0, loc_sd = 1'b0, loc_fs = 1'b0;
  logic [4:0]  word_len = 5'd7;
  logic        msb_first = 1'b0;
  logic [3:0]  words_per_frame = 4'd0;
  logic [2:0]  sync_mode = 3'd0;
  logic [3:0]  sync_len = 4'd0;
  logic [31:0] rx_word;
  logic        rx_valid;
  logic [1:0]  rx_size;
  logic [15:0] sync_data;
  logic        sync_valid;
  logic        busy;

  ssr_rx u_ssr_rx (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
    .ext_sck(ext_sck), .ext_sd(ext_sd), .ext_fs(ext_fs),
    .loc_sck(loc_sck), .loc_sd(loc_sd), .loc_fs(loc_fs),
    .word_len(word_len), .msb_first(msb_first), .words_per_frame(words_per_frame),
    .sync_mode(sync_mode), .sync_len(sync_len),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_size(rx_size),
    .sync_data(sync_data), .sync_valid(sync_valid), .busy(busy)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, n_got = 0, n_sv = 0, wide_err = 0;
  bit finished = 1'b0, prev_v = 1'b0;
  logic [31:0] got_w [16];
  logic [1:0]  got_s [16];
  int          got_c [16];
  logic [31:0] exp_w [16];
  int          last_raise [16];
  int          raise_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      if (n_got < 16) begin
        got_w[n_got] = rx_word; got_s[n_got] = rx_size; got_c[n_got] = cyc;
      end
      n_got = n_got + 1;
      if (prev_v) wide_err = wide_err + 1;
    end
    if (sync_valid) n_sv = n_sv + 1;
    prev_v = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [1:0] size_of(input int l);
    if (l <= 7) return 2'd0;
    if (l <= 15) return 2'd1;
    return 2'd2;
  endfunction

  task automatic send_bit(input logic d, input logic f);
    @(negedge clk);
    if (loop_en) begin
      loc_sck = 1'b0; loc_sd = d; loc_fs = f;
      ext_sck = $urandom_range(0, 1); ext_sd = $urandom_range(0, 1); ext_fs = $urandom_range(0, 1);
    end else begin
      ext_sck = 1'b0; ext_sd = d; ext_fs = f;
      loc_sck = $urandom_range(0, 1); loc_sd = $urandom_range(0, 1); loc_fs = $urandom_range(0, 1);
    end
    repeat (2) @(negedge clk);
    if (loop_en) loc_sck = 1'b1; else ext_sck = 1'b1;
    raise_cyc = cyc;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input int l, input bit msb, input int n, input int mode,
                           input int s, input bit restart, input bit lp, input string tag);
    logic [63:0] mask;
    logic [15:0] sv, prev_sync;
    bit sy;
    int sv_before;
    word_len = 5'(l); msb_first = msb; words_per_frame = 4'(n);
    sync_mode = 3'(mode); sync_len = 4'(s);
    sy = ((mode == 1) || (mode == 2)) && (s != 0);
    prev_sync = sync_data;
    sv = 16'($urandom) & 16'((32'd1 << s) - 1);
    mask = (64'd1 << (l + 1)) - 1;
    for (int w = 0; w <= n; w++) exp_w[w] = 32'($urandom) & 32'(mask);
    send_bit(1'b0, 1'b0);
    loop_en = lp;
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    n_got = 0; sv_before = n_sv;
    if (sy) begin
      for (int i = 0; i < s; i++) send_bit(sv[i], 1'b1);
    end else begin
      send_bit(1'($urandom), 1'b1);
    end
    for (int w = 0; w <= n; w++) begin
      for (int i = 0; i <= l; i++) begin
        send_bit(msb ? exp_w[w][l - i] : exp_w[w][i], (restart && w == 0 && i == 1));
        if (i == l) last_raise[w] = raise_cyc;
      end
    end
    for (int i = 0; i < 3; i++) send_bit(1'($urandom), 1'b0);
    chk(n_got == n + 1, {tag, " R4 word count"}, 64'(n_got), 64'(n + 1));
    chk(busy == 1'b0, {tag, " R4 idle after frame"}, 64'(busy), 64'd0);
    for (int w = 0; w <= n && w < n_got; w++) begin
      chk(got_w[w] == exp_w[w], {tag, msb ? " R3 R1 msb-first word" : " R2 R1 lsb-first word",
          lp ? " R7" : "", restart ? " R9" : ""}, 64'(got_w[w]), 64'(exp_w[w]));
      chk(got_s[w] == size_of(l), {tag, " R5 size tag"}, 64'(got_s[w]), 64'(size_of(l)));
      chk(got_c[w] == last_raise[w] + 2, {tag, " R6 valid timing"}, 64'(got_c[w]), 64'(last_raise[w] + 2));
    end
    if (sy) begin
      chk(n_sv - sv_before == 1, {tag, " R8 sync strobe"}, 64'(n_sv - sv_before), 64'd1);
      chk(sync_data == sv, {tag, " R8 sync data"}, 64'(sync_data), 64'(sv));
    end else begin
      chk(n_sv == sv_before, {tag, " R8 no sync strobe"}, 64'(n_sv - sv_before), 64'd0);
      chk(sync_data == prev_sync, {tag, " R8 sync data kept"}, 64'(sync_data), 64'(prev_sync));
    end
  endtask

  initial begin
    #(190000 * 10);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(rx_valid == 1'b0, "R6 reset valid", 64'(rx_valid), 64'd0);
    chk(busy == 1'b0, "R4 reset busy", 64'(busy), 64'd0);
    chk(rx_word == 32'd0, "R1 reset word", 64'(rx_word), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_frame(7,  1'b0, 0,  0, 0,  1'b0, 1'b0, "byte");
    run_frame(8,  1'b1, 1,  0, 0,  1'b0, 1'b0, "half-low");
    run_frame(15, 1'b0, 2,  5, 3,  1'b0, 1'b0, "half-high");
    run_frame(16, 1'b1, 0,  3, 5,  1'b0, 1'b0, "word-low");
    run_frame(31, 1'b1, 15, 2, 15, 1'b0, 1'b0, "max");
    run_frame(1,  1'b1, 3,  1, 1,  1'b0, 1'b0, "short");
    run_frame(5,  1'b0, 2,  2, 4,  1'b1, 1'b0, "restart");
    run_frame(12, 1'b1, 1,  1, 6,  1'b0, 1'b1, "loop");

    n_got = 0;
    for (int i = 0; i < 40; i++) send_bit(1'($urandom), 1'b0);
    chk(n_got == 0, "R10 no start no words", 64'(n_got), 64'd0);
    chk(wide_err == 0, "R6 strobe width", 64'(wide_err), 64'd0);

    for (int k = 0; k < 25; k++) begin
      run_frame(1 + ($urandom % 31), 1'($urandom), $urandom % 8, $urandom % 6,
                $urandom % 16, 1'($urandom), 1'($urandom), "random");
    end
    chk(wide_err == 0, "R6 strobe width final", 64'(wide_err), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule